// File: doc/BRIEF.md
# Translation Buffer with Protection Check

This block is a small fully associative cache of address translations. Each request carries a virtual address, a read or write flag, a privilege flag and a process identifier. In the same cycle, the block returns a physical address together with one of four outcomes:

- a translation hit;
- a miss, which also raises a request to an external page walker;
- a page fault, for a cached page that is not resident;
- a protection fault, for an access that the page's rights forbid.

The walker answers a miss by presenting a refill entry, which the block stores on the next clock edge. When the buffer is full, a round-robin victim pointer picks the slot to overwrite. A flush input empties the whole buffer in one cycle.

The low `OFS_W` bits of the virtual address are the page offset and pass through unchanged. The upper `VPN_W` bits are the virtual page number, and translation replaces them with a `PFN_W`-bit frame number. Each entry is tagged with the process identifier, so the same page number used by two processes resolves to two different frames.

Top module: `xlat_cache`

## Requirements
- R1: On a hit, `pa` is the cached frame number placed above the unchanged low `OFS_W` bits of `lk_vaddr`. In every other case `pa` is zero.
- R2: A lookup matches only an occupied entry whose page number and process tag both equal the request. With no match, `miss` and `walk_req` are high, and `walk_vpn` and `walk_pid` carry the requested page number and process identifier.
- R3: A matching entry whose present flag is 0 gives `pg_fault`, whatever its permission bits.
- R4: On a present entry, a read (`lk_write`=0) needs the entry's read bit and a write (`lk_write`=1) needs its write bit. If the needed bit is clear, the result is `prot_fault`, not a hit.
- R5: A present entry marked supervisor-only gives `prot_fault` when accessed with `lk_user`=1, even if its read and write bits allow the access.
- R6: While `lk_valid` is high, exactly one of `hit`, `miss`, `pg_fault` and `prot_fault` is high. While `lk_valid` is low, all four are low, as is `walk_req`.
- R7: A refill (`fill_valid`) is stored at the clock edge and takes effect for lookups from the next cycle. A refill whose page number and process identifier match a stored entry overwrites that entry in place.
- R8: A refill for a new translation goes to the slot under the victim pointer, which then advances by one and wraps after the last slot. In-place updates do not move the pointer. Reset and flush return the pointer to slot 0, so after a flush the ninth new refill of an 8-entry buffer evicts the first.
- R9: `flush` empties every entry at the next clock edge and takes priority over a refill in the same cycle.
- R10: After reset the buffer is empty, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty all entries |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | VPN_W+OFS_W | Virtual address |
| lk_write | input | 1 | 1 for a write, 0 for a read |
| lk_user | input | 1 | 1 for user privilege, 0 for supervisor |
| lk_pid | input | PID_W | Requesting process identifier |
| pa | output | PFN_W+OFS_W | Translated physical address |
| hit | output | 1 | Translation completed |
| miss | output | 1 | No matching entry |
| pg_fault | output | 1 | Matching entry not resident |
| prot_fault | output | 1 | Access rights violated |
| walk_req | output | 1 | Request to the page walker |
| walk_vpn | output | VPN_W | Page number to walk |
| walk_pid | output | PID_W | Process identifier to walk |
| fill_valid | input | 1 | Refill entry present |
| fill_vpn | input | VPN_W | Refill page number |
| fill_pid | input | PID_W | Refill process tag |
| fill_present | input | 1 | Page resident |
| fill_rd | input | 1 | Read allowed |
| fill_wr | input | 1 | Write allowed |
| fill_sup | input | 1 | Supervisor-only page |
| fill_pfn | input | PFN_W | Refill frame number |

## Verification
The properties assume that lookup inputs stay stable between clock edges, since the outcome is combinational. They also assume the walker never writes the same page number and process pair into two slots; the in-place update rule relies on this to keep matches one-hot. The bench changes inputs only at falling edges and samples a few nanoseconds later. It always refills through the block's own port, so a duplicate entry can never form. Refills and flushes are spaced so that each one is observed by a lookup in the following cycle.

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int OFS_W   = 12,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 16,
  parameter int PID_W   = 4,
  parameter int ENTRIES = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   lk_valid,
  input  logic [VPN_W+OFS_W-1:0] lk_vaddr,
  input  logic                   lk_write,
  input  logic                   lk_user,
  input  logic [PID_W-1:0]       lk_pid,
  output logic [PFN_W+OFS_W-1:0] pa,
  output logic                   hit,
  output logic                   miss,
  output logic                   pg_fault,
  output logic                   prot_fault,
  output logic                   walk_req,
  output logic [VPN_W-1:0]       walk_vpn,
  output logic [PID_W-1:0]       walk_pid,
  input  logic                   fill_valid,
  input  logic [VPN_W-1:0]       fill_vpn,
  input  logic [PID_W-1:0]       fill_pid,
  input  logic                   fill_present,
  input  logic                   fill_rd,
  input  logic                   fill_wr,
  input  logic                   fill_sup,
  input  logic [PFN_W-1:0]       fill_pfn
);
  localparam int VA_W  = VPN_W + OFS_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] occ, pres, prd, pwr, psup;
  logic [VPN_W-1:0]   tag_vpn [ENTRIES];
  logic [PID_W-1:0]   tag_pid [ENTRIES];
  logic [PFN_W-1:0]   frame   [ENTRIES];
  logic [IDX_W-1:0]   victim;

  logic [VPN_W-1:0]   req_vpn;
  logic [ENTRIES-1:0] lk_match, fl_match;

  assign req_vpn = lk_vaddr[VA_W-1:OFS_W];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign lk_match[i] = occ[i] && tag_vpn[i] == req_vpn  && tag_pid[i] == lk_pid;
    assign fl_match[i] = occ[i] && tag_vpn[i] == fill_vpn && tag_pid[i] == fill_pid;
  end

  logic             sel_pres, sel_rd, sel_wr, sel_sup;
  logic [PFN_W-1:0] sel_pfn;
  logic [IDX_W-1:0] upd_idx;

  always_comb begin
    sel_pres = 1'b0; sel_rd = 1'b0; sel_wr = 1'b0; sel_sup = 1'b0;
    sel_pfn  = '0;
    upd_idx  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) begin
        sel_pres = sel_pres | pres[i];
        sel_rd   = sel_rd   | prd[i];
        sel_wr   = sel_wr   | pwr[i];
        sel_sup  = sel_sup  | psup[i];
        sel_pfn  = sel_pfn  | frame[i];
      end
      if (fl_match[i]) upd_idx = upd_idx | IDX_W'(i);
    end
  end

  logic found, allowed;
  assign found      = |lk_match;
  assign allowed    = (lk_write ? sel_wr : sel_rd) && !(sel_sup && lk_user);
  assign miss       = lk_valid && !found;
  assign pg_fault   = lk_valid && found && !sel_pres;
  assign prot_fault = lk_valid && found && sel_pres && !allowed;
  assign hit        = lk_valid && found && sel_pres && allowed;
  assign pa         = hit ? {sel_pfn, lk_vaddr[OFS_W-1:0]} : '0;
  assign walk_req   = miss;
  assign walk_vpn   = miss ? req_vpn : '0;
  assign walk_pid   = miss ? lk_pid  : '0;

  logic             in_place;
  logic [IDX_W-1:0] wr_idx;
  assign in_place = |fl_match;
  assign wr_idx   = in_place ? upd_idx : victim;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      occ    <= '0;
      victim <= '0;
    end else if (fill_valid) begin
      occ[wr_idx] <= 1'b1;
      if (!in_place) victim <= (victim == LAST) ? '0 : victim + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_valid && !flush) begin
      tag_vpn[wr_idx] <= fill_vpn;
      tag_pid[wr_idx] <= fill_pid;
      frame[wr_idx]   <= fill_pfn;
      pres[wr_idx]    <= fill_present;
      prd[wr_idx]     <= fill_rd;
      pwr[wr_idx]     <= fill_wr;
      psup[wr_idx]    <= fill_sup;
    end
  end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int OFS_W = 12,
  parameter int VPN_W = 20,
  parameter int PFN_W = 16,
  parameter int PID_W = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   flush,
  input logic                   lk_valid,
  input logic [VPN_W+OFS_W-1:0] lk_vaddr,
  input logic [PID_W-1:0]       lk_pid,
  input logic [PFN_W+OFS_W-1:0] pa,
  input logic                   hit,
  input logic                   miss,
  input logic                   pg_fault,
  input logic                   prot_fault,
  input logic                   walk_req,
  input logic [VPN_W-1:0]       walk_vpn,
  input logic                   fill_valid,
  input logic [VPN_W-1:0]       fill_vpn,
  input logic [PID_W-1:0]       fill_pid
);
  localparam int VA_W = VPN_W + OFS_W;

  // R6
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $countones({hit, miss, pg_fault, prot_fault}) == 1);

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !(hit || miss || pg_fault || prot_fault || walk_req));

  // R1
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> pa[OFS_W-1:0] == lk_vaddr[OFS_W-1:0]);

  // R2
  walk_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req |-> miss && walk_vpn == lk_vaddr[VA_W-1:OFS_W]);

  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!lk_valid || miss));

  // R7
  fill_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !flush) |=> !(lk_valid && miss &&
      lk_vaddr[VA_W-1:OFS_W] == $past(fill_vpn) && lk_pid == $past(fill_pid)));
endmodule

bind xlat_cache xlat_cache_chk #(
  .OFS_W(OFS_W), .VPN_W(VPN_W), .PFN_W(PFN_W), .PID_W(PID_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid),
  .lk_vaddr(lk_vaddr), .lk_pid(lk_pid), .pa(pa), .hit(hit), .miss(miss),
  .pg_fault(pg_fault), .prot_fault(prot_fault), .walk_req(walk_req),
  .walk_vpn(walk_vpn), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
  .fill_pid(fill_pid)
);

// File: tb/xlat_cache_tb_top.sv
module xlat_cache_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_write = 1'b0;
  logic        lk_user = 1'b0;
  logic [3:0]  lk_pid = '0;
  logic [27:0] pa;
  logic        hit, miss, pg_fault, prot_fault, walk_req;
  logic [19:0] walk_vpn;
  logic [3:0]  walk_pid;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [3:0]  fill_pid = '0;
  logic        fill_present = 1'b0, fill_rd = 1'b0, fill_wr = 1'b0, fill_sup = 1'b0;
  logic [15:0] fill_pfn = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xlat_cache dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid),
    .lk_vaddr(lk_vaddr), .lk_write(lk_write), .lk_user(lk_user), .lk_pid(lk_pid),
    .pa(pa), .hit(hit), .miss(miss), .pg_fault(pg_fault), .prot_fault(prot_fault),
    .walk_req(walk_req), .walk_vpn(walk_vpn), .walk_pid(walk_pid),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pid(fill_pid),
    .fill_present(fill_present), .fill_rd(fill_rd), .fill_wr(fill_wr),
    .fill_sup(fill_sup), .fill_pfn(fill_pfn)
  );

  // outcome codes: 0 hit, 1 miss, 2 page fault, 3 protection fault
  // vector: {vaddr[31:0], write, user, pid[3:0], code[1:0], pfn[15:0]}
  localparam int NV = 13;
  localparam logic [55:0] VEC [NV] = '{
    {32'h0001_0123, 1'b0, 1'b1, 4'd1, 2'd0, 16'h0A01},
    {32'h0001_0123, 1'b1, 1'b1, 4'd1, 2'd0, 16'h0A01},
    {32'h0001_1FFF, 1'b1, 1'b1, 4'd1, 2'd3, 16'h0000},
    {32'h0001_1000, 1'b0, 1'b1, 4'd1, 2'd0, 16'h0A02},
    {32'h0001_2456, 1'b0, 1'b1, 4'd1, 2'd3, 16'h0000},
    {32'h0001_2456, 1'b1, 1'b0, 4'd1, 2'd0, 16'h0A03},
    {32'h0001_3000, 1'b0, 1'b0, 4'd1, 2'd2, 16'h0000},
    {32'h0001_0ABC, 1'b0, 1'b1, 4'd2, 2'd0, 16'h0B01},
    {32'h0001_0000, 1'b0, 1'b1, 4'd3, 2'd1, 16'h0000},
    {32'h0009_9000, 1'b0, 1'b0, 4'd1, 2'd1, 16'h0000},
    {32'h0001_4010, 1'b0, 1'b0, 4'd1, 2'd3, 16'h0000},
    {32'h0001_4010, 1'b1, 1'b1, 4'd1, 2'd0, 16'h0A05},
    {32'h0001_3FFF, 1'b1, 1'b1, 4'd1, 2'd2, 16'h0000}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [3:0] pid, input logic p,
                      input logic r, input logic w, input logic s, input logic [15:0] pfn);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_pid = pid;
    fill_present = p; fill_rd = r; fill_wr = w; fill_sup = s; fill_pfn = pfn;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic look(input logic [31:0] va, input logic wr, input logic usr,
                      input logic [3:0] pid);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va; lk_write = wr; lk_user = usr; lk_pid = pid;
    #3;
  endtask

  task automatic expect_out(input string tag, input logic [1:0] code, input logic [15:0] pfn);
    logic [3:0] flags;
    flags = 4'b0001 << code;
    check(tag, {60'd0, prot_fault, pg_fault, miss, hit}, {60'd0, flags});
    check(tag, {36'd0, pa}, (code == 2'd0) ? {36'd0, pfn, lk_vaddr[11:0]} : 64'd0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state: no outcome while idle, lookup misses
    #3;
    check("R6 idle", {60'd0, hit, miss, pg_fault, prot_fault}, 64'd0);
    look(32'h0001_0000, 1'b0, 1'b0, 4'd1);
    expect_out("R10 empty after reset", 2'd1, 16'h0);
    check("R2 walk req", {44'd0, walk_req, walk_vpn}, {44'd0, 1'b1, 20'h00010});
    check("R2 walk pid", {60'd0, walk_pid}, 64'd1);
    lk_valid = 1'b0;

    fill(20'h00010, 4'd1, 1, 1, 1, 0, 16'h0A01);
    fill(20'h00011, 4'd1, 1, 1, 0, 0, 16'h0A02);
    fill(20'h00012, 4'd1, 1, 1, 1, 1, 16'h0A03);
    fill(20'h00013, 4'd1, 0, 1, 1, 0, 16'h0000);
    fill(20'h00010, 4'd2, 1, 1, 1, 0, 16'h0B01);
    fill(20'h00014, 4'd1, 1, 0, 1, 0, 16'h0A05);

    // R1 R2 R3 R4 R5 table walk
    for (int k = 0; k < NV; k++) begin
      look(VEC[k][55:24], VEC[k][23], VEC[k][22], VEC[k][21:18]);
      expect_out($sformatf("R1-table R3 R4 R5 vec%0d", k), VEC[k][17:16], VEC[k][15:0]);
    end
    lk_valid = 1'b0;
    #3;
    check("R6 idle after lookups", {60'd0, hit, miss, pg_fault, prot_fault, walk_req} , 64'd0);

    // R7 refill visible in the following cycle
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = 20'h00020; fill_pid = 4'd1;
    fill_present = 1; fill_rd = 1; fill_wr = 1; fill_sup = 0; fill_pfn = 16'h0C20;
    lk_valid = 1'b1; lk_vaddr = 32'h0002_0777; lk_write = 0; lk_user = 1; lk_pid = 4'd1;
    #3;
    expect_out("R7 before edge", 2'd1, 16'h0);
    @(negedge clk);
    fill_valid = 1'b0;
    #3;
    expect_out("R7 after edge", 2'd0, 16'h0C20);
    // R7 in-place update
    lk_valid = 1'b0;
    fill(20'h00011, 4'd1, 1, 1, 1, 0, 16'h0D02);
    look(32'h0001_1234, 1'b1, 1'b1, 4'd1);
    expect_out("R7 in place", 2'd0, 16'h0D02);

    // R9 flush empties, wins over simultaneous refill
    @(negedge clk);
    lk_valid = 1'b0;
    flush = 1'b1;
    fill_valid = 1'b1; fill_vpn = 20'h00030; fill_pid = 4'd1; fill_pfn = 16'h0E30;
    fill_present = 1; fill_rd = 1; fill_wr = 1; fill_sup = 0;
    @(negedge clk);
    flush = 1'b0; fill_valid = 1'b0;
    look(32'h0001_0123, 1'b0, 1'b1, 4'd1);
    expect_out("R9 flushed entry", 2'd1, 16'h0);
    look(32'h0003_0000, 1'b0, 1'b1, 4'd1);
    expect_out("R9 flush beats refill", 2'd1, 16'h0);
    lk_valid = 1'b0;

    // R8 round-robin replacement from slot 0
    for (int k = 0; k < 8; k++) fill(20'h00100 + 20'(k), 4'd1, 1, 1, 1, 0, 16'h1000 + 16'(k));
    fill(20'h00200, 4'd1, 1, 1, 1, 0, 16'h2000);
    look(32'h0010_0000, 1'b0, 1'b1, 4'd1);
    expect_out("R8 slot0 evicted", 2'd1, 16'h0);
    look(32'h0010_1000, 1'b0, 1'b1, 4'd1);
    expect_out("R8 slot1 kept", 2'd0, 16'h1001);
    look(32'h0020_0000, 1'b0, 1'b1, 4'd1);
    expect_out("R8 new entry", 2'd0, 16'h2000);
    lk_valid = 1'b0;
    fill(20'h00201, 4'd1, 1, 1, 1, 0, 16'h2001);
    look(32'h0010_1000, 1'b0, 1'b1, 4'd1);
    expect_out("R8 slot1 evicted", 2'd1, 16'h0);
    lk_valid = 1'b0;
    // in-place update must not advance the pointer (still at slot 2)
    fill(20'h00105, 4'd1, 1, 1, 1, 0, 16'h1F05);
    fill(20'h00202, 4'd1, 1, 1, 1, 0, 16'h2002);
    look(32'h0010_2000, 1'b0, 1'b1, 4'd1);
    expect_out("R8 slot2 evicted", 2'd1, 16'h0);
    look(32'h0010_3000, 1'b0, 1'b1, 4'd1);
    expect_out("R8 slot3 kept", 2'd0, 16'h1003);
    look(32'h0010_5000, 1'b0, 1'b1, 4'd1);
    expect_out("R8 updated kept", 2'd0, 16'h1F05);
    lk_valid = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule